// File: doc/BRIEF.md
# Two-Beat Burst SRAM Front End

This block is a cycle-accurate, synthesizable model of the synchronous side of a double-data-rate SRAM. It has separate write and read data paths. A host starts one transaction per clock by driving the active-low load strobe low. A direction bit then selects read or write for the address presented in that cycle. Every transaction moves exactly two words. The two DDR beats of a clock are carried in one clock domain as a beat-0 bus and a beat-1 bus. Beat 0 stands for the word on the complementary clock edge and beat 1 for the word on the true edge.

A write carries both beats in its command cycle, each beat with its own active-low byte enables. The block parks the write in a one-entry pending register and commits it to the array on the following clock. A read issued in the cycle after a write therefore merges the pending bytes over the array contents, so it always returns the newest data. Read words come out after a fixed, parameterised number of cycles and are marked by a valid flag.

A three-state controller tracks the bus cycle.
- ST_LOAD is the load-new-address state. It is entered at reset and after any NOP.
- ST_READ is the read-double state. It is entered on any cycle with a read command.
- ST_WRITE is the write-double state. It is entered on any cycle with a write command.

Every state can move to every other state on the next clock. The transitions are named NOP-to-load, load-read and load-write.

Top module: `burst2_sram_front`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rvalid` is low.
- R2: When `load_n` is high at a rising clock edge, the cycle is a NOP. The address, data and byte enables are ignored, no array word changes, and no read result is produced for that cycle.
- R3: When `load_n` is low, `rd_wr` high starts a read of `addr` and `rd_wr` low starts a write of `addr`.
- R4: A burst covers two words at `addr`. A write stores `wdata0` in word-select 0 and `wdata1` in word-select 1. A read returns word-select 0 on `rdata0` and word-select 1 on `rdata1`.
- R5: Bit b of `wbe0_n` controls bits [9b+8:9b] of beat 0, and bit b of `wbe1_n` controls the same bits of beat 1, each bit independently. The value 0 writes the byte. The value 1 keeps the byte's previous contents.
- R6: Read data and `rvalid` appear RD_LAT cycles after the read command cycle. `rvalid` is high for exactly one cycle per read and low in every other cycle.
- R7: A read issued in the cycle right after a write to the same address returns the newly written bytes merged with the unchanged old bytes. This also holds after two successive writes to that address.
- R8: The controller is in ST_LOAD after a NOP, in ST_READ after a read command and in ST_WRITE after a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low transaction strobe |
| rd_wr | input | 1 | 1 = read, 0 = write (used when load_n is low) |
| addr | input | ADDR_W | Burst address |
| wdata0 | input | WORD_W | Write beat 0 (word-select 0) |
| wdata1 | input | WORD_W | Write beat 1 (word-select 1) |
| wbe0_n | input | WORD_W/9 | Active-low byte enables for beat 0 |
| wbe1_n | input | WORD_W/9 | Active-low byte enables for beat 1 |
| rdata0 | output | WORD_W | Read beat 0 (word-select 0) |
| rdata1 | output | WORD_W | Read beat 1 (word-select 1) |
| rvalid | output | 1 | High when rdata0/rdata1 carry a read result |

## Verification
The bench builds the block with WORD_W = 18, ADDR_W = 3 and RD_LAT = 3. With only eight burst addresses, random traffic often lands a read right behind a write to the same address, so the pending-write bypass and its per-byte merge are exercised heavily. A latency of 3 rather than the default 2 keeps up to three reads in flight in the pipeline and tests the parameterised delay chain away from its default. Two byte lanes per beat, each with its own enable, make every mask pattern reachable.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
    localparam int BYTE_W = 9;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;
endpackage

// File: rtl/burst2_ctrl.sv
module burst2_ctrl
    import burst2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    input  logic rd_wr,
    output logic rd_go,
    output logic wr_go
);
    bus_state_e state;
    bus_state_e next_state;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= next_state;
    end

    // next state and command strobes
    always_comb begin
        next_state = ST_LOAD;
        rd_go      = 1'b0;
        wr_go      = 1'b0;
        if (!load_n) next_state = rd_wr ? ST_READ : ST_WRITE;
        unique case (next_state)
            ST_LOAD:  ;
            ST_READ:  rd_go = 1'b1;
            ST_WRITE: wr_go = 1'b1;
            default:  ;
        endcase
    end

    a_r2_nop_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> (state == ST_LOAD));
    a_r8_read_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && rd_wr) |=> (state == ST_READ));
    a_r8_write_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !rd_wr) |=> (state == ST_WRITE));
    a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_go, wr_go}));
endmodule

// File: rtl/burst2_array.sv
module burst2_array
    import burst2_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6,
    parameter int NB     = WORD_W / BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_go,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [1:0][WORD_W-1:0]      wd,
    input  logic [1:0][NB-1:0]          wbe_n,
    output logic [1:0][WORD_W-1:0]      rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic                   pend_vld;
    logic [ADDR_W-1:0]      pend_addr;
    logic [1:0][WORD_W-1:0] pend_d;
    logic [1:0][NB-1:0]     pend_m;
    logic                   hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_vld <= 1'b0;
        else        pend_vld <= wr_go;
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            pend_addr <= addr;
            pend_d    <= wd;
            pend_m    <= ~wbe_n;
        end
    end

    assign hit = pend_vld && (pend_addr == addr);

    for (genvar g = 0; g < 2; g++) begin : g_beat
        logic [WORD_W-1:0] store [DEPTH];
        logic [WORD_W-1:0] merged;

        always_ff @(posedge clk) begin
            if (pend_vld) begin
                for (int b = 0; b < NB; b++) begin
                    if (pend_m[g][b])
                        store[pend_addr][b*BYTE_W +: BYTE_W] <= pend_d[g][b*BYTE_W +: BYTE_W];
                end
            end
        end

        always_comb begin
            merged = store[addr];
            if (hit) begin
                for (int b = 0; b < NB; b++) begin
                    if (pend_m[g][b])
                        merged[b*BYTE_W +: BYTE_W] = pend_d[g][b*BYTE_W +: BYTE_W];
                end
            end
        end

        assign rd[g] = merged;
    end

    a_r7_pending_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (pend_vld && pend_addr == $past(addr)));
    a_r2_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> !pend_vld);
endmodule

// File: rtl/burst2_rpipe.sv
module burst2_rpipe #(
    parameter int WORD_W = 18,
    parameter int RD_LAT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_go,
    input  logic [1:0][WORD_W-1:0] din,
    output logic [1:0][WORD_W-1:0] dout,
    output logic                   vld
);
    localparam int CW = $clog2(RD_LAT + 2);

    logic [RD_LAT-1:0]      v;
    logic [1:0][WORD_W-1:0] sd [RD_LAT];
    logic [CW-1:0]          outst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v <= '0;
        end else begin
            v[0] <= rd_go;
            for (int i = 1; i < RD_LAT; i++) v[i] <= v[i-1];
        end
    end

    always_ff @(posedge clk) begin
        sd[0] <= din;
        for (int i = 1; i < RD_LAT; i++) sd[i] <= sd[i-1];
    end

    assign vld  = v[RD_LAT-1];
    assign dout = sd[RD_LAT-1];

    // reads in flight, used by the checks below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) outst <= '0;
        else        outst <= outst + CW'(rd_go) - CW'(vld);
    end

    a_r6_in_flight_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= CW'(RD_LAT));
    a_r6_no_orphan_valid: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (outst != '0));
    a_r4_data_known: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> !$isunknown(dout));
endmodule

// File: rtl/burst2_sram_front.sv
module burst2_sram_front
    import burst2_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6,
    parameter int RD_LAT = 2,
    localparam int NB    = WORD_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata0,
    input  logic [WORD_W-1:0] wdata1,
    input  logic [NB-1:0]     wbe0_n,
    input  logic [NB-1:0]     wbe1_n,
    output logic [WORD_W-1:0] rdata0,
    output logic [WORD_W-1:0] rdata1,
    output logic              rvalid
);
    logic                   rd_go;
    logic                   wr_go;
    logic [1:0][WORD_W-1:0] wd;
    logic [1:0][NB-1:0]     wbe_n;
    logic [1:0][WORD_W-1:0] arr_rd;
    logic [1:0][WORD_W-1:0] pipe_q;

    assign wd[0]    = wdata0;
    assign wd[1]    = wdata1;
    assign wbe_n[0] = wbe0_n;
    assign wbe_n[1] = wbe1_n;

    burst2_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .rd_wr  (rd_wr),
        .rd_go  (rd_go),
        .wr_go  (wr_go)
    );

    burst2_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NB(NB)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (wr_go),
        .addr   (addr),
        .wd     (wd),
        .wbe_n  (wbe_n),
        .rd     (arr_rd)
    );

    burst2_rpipe #(.WORD_W(WORD_W), .RD_LAT(RD_LAT)) u_rpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_go  (rd_go),
        .din    (arr_rd),
        .dout   (pipe_q),
        .vld    (rvalid)
    );

    assign rdata0 = pipe_q[0];
    assign rdata1 = pipe_q[1];

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rvalid);
endmodule

// File: tb/burst2_sram_front_tb.sv
`timescale 1ns/1ps
module burst2_sram_front_tb;
    localparam int W     = 18;
    localparam int AW    = 3;
    localparam int LAT   = 3;
    localparam int NB    = 2;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_n, rd_wr;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata0, wdata1, rdata0, rdata1;
    logic [NB-1:0] wbe0_n, wbe1_n;
    logic          rvalid;

    burst2_sram_front #(.WORD_W(W), .ADDR_W(AW), .RD_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr(rd_wr), .addr(addr),
        .wdata0(wdata0), .wdata1(wdata1), .wbe0_n(wbe0_n), .wbe1_n(wbe1_n),
        .rdata0(rdata0), .rdata1(rdata1), .rvalid(rvalid)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [W-1:0] model [DEPTH][2];
    bit           ev   [8];
    logic [W-1:0] e0   [8];
    logic [W-1:0] e1   [8];
    string        etag [8];

    function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw,
                                           logic [NB-1:0] ben);
        logic [W-1:0] r = old;
        for (int b = 0; b < NB; b++)
            if (!ben[b]) r[b*9 +: 9] = nw[b*9 +: 9];
        return r;
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cyc=%0d actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    task automatic step(input logic ld_n, input logic rw, input logic [AW-1:0] a,
                        input logic [W-1:0] d0, input logic [W-1:0] d1,
                        input logic [NB-1:0] b0, input logic [NB-1:0] b1, input string tag);
        int slot;
        @(negedge clk);
        slot = cyc % 8;
        check("R6", "rvalid", W'(rvalid), W'(ev[slot]));
        if (ev[slot]) begin
            check(etag[slot], "rdata0", rdata0, e0[slot]);
            check(etag[slot], "rdata1", rdata1, e1[slot]);
        end
        ev[slot] = 1'b0;
        load_n = ld_n; rd_wr = rw; addr = a;
        wdata0 = d0; wdata1 = d1; wbe0_n = b0; wbe1_n = b1;
        if (!ld_n) begin
            if (rw) begin
                slot = (cyc + LAT) % 8;
                ev[slot] = 1'b1; e0[slot] = model[a][0]; e1[slot] = model[a][1];
                etag[slot] = tag;
            end else begin
                model[a][0] = merge(model[a][0], d0, b0);
                model[a][1] = merge(model[a][1], d1, b1);
            end
        end
        cyc++;
    endtask

    task automatic nop(int n);
        for (int i = 0; i < n; i++)
            step(1'b1, 1'b0, AW'($urandom), W'($urandom), W'($urandom), 2'b00, 2'b00, "R2");
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) ev[i] = 1'b0;
        rst_n = 1'b0; load_n = 1'b1; rd_wr = 1'b0; addr = '0;
        wdata0 = '0; wdata1 = '0; wbe0_n = '1; wbe1_n = '1;
        repeat (3) @(negedge clk);
        check("R1", "rvalid in reset", W'(rvalid), '0);
        rst_n = 1'b1;

        // R4: fill every burst, then read back both words
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b0, AW'(a), W'(18'h100 + a), W'(18'h2A000 + a), 2'b00, 2'b00, "R4");
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b1, AW'(a), '0, '0, 2'b00, 2'b00, "R4");
        nop(LAT);

        // R5: per-beat independent byte masks
        step(1'b0, 1'b0, 3'd2, 18'h3FFFF, 18'h15555, 2'b01, 2'b10, "R5");
        nop(2);
        step(1'b0, 1'b1, 3'd2, '0, '0, 2'b11, 2'b11, "R5");
        step(1'b0, 1'b0, 3'd3, 18'h0AAAA, 18'h33333, 2'b11, 2'b11, "R5");
        step(1'b0, 1'b1, 3'd3, '0, '0, 2'b00, 2'b00, "R5");
        nop(LAT);

        // R2: NOP with live-looking write data must not change address 5
        step(1'b1, 1'b0, 3'd5, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, "R2");
        step(1'b1, 1'b1, 3'd5, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, "R2");
        nop(2);
        step(1'b0, 1'b1, 3'd5, '0, '0, 2'b00, 2'b00, "R2");
        nop(LAT);

        // R7: read right behind a partial write, and behind two writes
        step(1'b0, 1'b0, 3'd6, 18'h12345, 18'h2BCDE, 2'b10, 2'b01, "R7");
        step(1'b0, 1'b1, 3'd6, '0, '0, 2'b00, 2'b00, "R7");
        step(1'b0, 1'b0, 3'd7, 18'h00111, 18'h00222, 2'b00, 2'b00, "R7");
        step(1'b0, 1'b0, 3'd7, 18'h3FE00, 18'h3FE00, 2'b01, 2'b10, "R7");
        step(1'b0, 1'b1, 3'd7, '0, '0, 2'b00, 2'b00, "R7");
        step(1'b0, 1'b1, 3'd7, '0, '0, 2'b00, 2'b00, "R7");
        nop(LAT);

        // R3 and R8: random mix of reads, writes and NOPs drives all controller transitions
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) == 0, $urandom % 2, AW'($urandom), W'($urandom), W'($urandom),
                 NB'($urandom), NB'($urandom), "R3");
        nop(LAT + 2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule